// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits between a bus write port and a peripheral's register file and decides, write by write, whether the register file may see the write. It holds the register file write-protected until software stores two fixed 32-bit key words, each into its own key address. While both stored keys are correct, writes to every other address pass straight through; as soon as either key address receives any other word, protection is restored on the next cycle.

Reads are never gated, and the key addresses are always writable, so software can unlock, update, and relock with plain bus writes. Writes made while the block is locked are dropped without any indication. A single output shows whether the block is currently locked.

Top module: `reg_write_lock`

## Requirements
- R1: After reset, and after any later reset, the block is locked: `locked_o` is 1.
- R2: Writing 0x83E70B13 to address 0x6C and 0x95A4F1E0 to address 0x70, in either order, unlocks the block; `locked_o` drops to 0 in the cycle after the clock edge that takes the second of these writes.
- R3: While unlocked, a write to any address other than 0x6C or 0x70 raises `reg_we_o` in the same cycle, with `reg_addr_o` and `reg_wdata_o` equal to the bus address and data.
- R4: While locked, a write to any address other than 0x6C or 0x70 is dropped: `reg_we_o` stays 0.
- R5: Writing any word other than its key value to 0x6C or 0x70, zero included, locks the block from the next cycle on, whatever the other key holds.
- R6: With only one of the two keys correctly written, the block stays locked.
- R7: `reg_re_o` follows `rd_en_i` in the same cycle whether the block is locked or unlocked.
- R8: A write to 0x6C or 0x70 never raises `reg_we_o`, in either state.
- R9: A key address and key data presented with `wr_en_i` low change nothing in the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| reg_we_o | output | 1 | Write enable to the protected register file |
| reg_re_o | output | 1 | Read enable to the register file |
| reg_addr_o | output | 8 | Address forwarded to the register file |
| reg_wdata_o | output | 32 | Write data forwarded to the register file |
| locked_o | output | 1 | 1 while protected writes are blocked |

## Verification
The unlock sequence is driven with the two keys in both orders, so a design that only accepts one order is caught. Near-miss values (one bit off from a key), a single correct key, and writes of zero each separate a correct full-word comparison from one that checks only part of the word or ignores one slot. Protected writes are issued right before and after each lock transition, which shows whether the gate uses the stored state, and key writes issued while unlocked confirm that key addresses never leak to the register file. Reads in both states and key-valued traffic with the write strobe low show that neither path disturbs the lock.

// File: rtl/reg_write_lock_pkg.sv
package reg_write_lock_pkg;
  localparam int unsigned NUM_KEYS = 2;

  typedef enum logic [0:0] {
    KEY_FIRST  = 1'b0,
    KEY_SECOND = 1'b1
  } key_idx_e;
endpackage

// File: rtl/key_slot.sv
module key_slot #(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          DATA_W    = 32,
  parameter logic [ADDR_W-1:0]    SLOT_ADDR = '0,
  parameter logic [DATA_W-1:0]    SLOT_VAL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              match_o
);
  logic match_q;

  assign hit_o = (addr_i == SLOT_ADDR);

  // only the comparison result is kept, not the word itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                match_q <= 1'b0;
    else if (wr_en_i && hit_o)  match_q <= (wdata_i == SLOT_VAL);
  end

  assign match_o = match_q;

  // R2
  match_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(wr_en_i && (addr_i == SLOT_ADDR) && (wdata_i == SLOT_VAL)));

  // R5
  wrong_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == SLOT_ADDR) && (wdata_i != SLOT_VAL)) |=> !match_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(match_o));
endmodule

// File: rtl/write_gate.sv
module write_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              key_hit_i,
  input  logic              unlocked_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  assign reg_we_o    = wr_en_i & ~key_hit_i & unlocked_i;
  assign reg_re_o    = rd_en_i;
  assign reg_addr_o  = addr_i;
  assign reg_wdata_o = wdata_i;

  // R4
  locked_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> !reg_we_o);

  // R8
  key_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit_i |-> !reg_we_o);

  // R3
  open_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unlocked_i && !key_hit_i) |-> reg_we_o);
endmodule

// File: rtl/reg_write_lock.sv
module reg_write_lock
  import reg_write_lock_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4_F1E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              locked_o
);
  localparam logic [NUM_KEYS-1:0][ADDR_W-1:0] SLOT_ADDRS = {KEY1_ADDR, KEY0_ADDR};
  localparam logic [NUM_KEYS-1:0][DATA_W-1:0] SLOT_VALS  = {KEY1_VAL, KEY0_VAL};

  logic [NUM_KEYS-1:0] slot_hit;
  logic [NUM_KEYS-1:0] slot_match;
  logic                unlocked;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
    key_slot #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SLOT_ADDR (SLOT_ADDRS[k]),
      .SLOT_VAL  (SLOT_VALS[k])
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .hit_o   (slot_hit[k]),
      .match_o (slot_match[k])
    );
  end

  assign unlocked = &slot_match;
  assign locked_o = ~unlocked;

  write_gate #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .key_hit_i   (|slot_hit),
    .unlocked_i  (unlocked),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o)
  );

  // R2
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(wr_en_i && ((addr_i == KEY0_ADDR) || (addr_i == KEY1_ADDR))));

  // R5
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (((addr_i == KEY0_ADDR) && (wdata_i != KEY0_VAL)) ||
                 ((addr_i == KEY1_ADDR) && (wdata_i != KEY1_VAL)))) |=> locked_o);
endmodule

// File: tb/reg_write_lock_test.sv
`timescale 1ns/1ps
module reg_write_lock_test;
  localparam logic [7:0]  A_K0 = 8'h6C;
  localparam logic [7:0]  A_K1 = 8'h70;
  localparam logic [31:0] V_K0 = 32'h83E7_0B13;
  localparam logic [31:0] V_K1 = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        reg_we, reg_re, locked;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_write_lock uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .rd_en_i     (rd_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .locked_o    (locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write cycle; checks the gate output mid-cycle
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic exp_we, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    #1;
    chk(tag, {31'd0, reg_we}, {31'd0, exp_we});
    if (exp_we) begin
      chk(tag, {24'd0, reg_addr}, {24'd0, a});
      chk(tag, reg_wdata, d);
    end
    @(posedge clk);
    #1 wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic chk_lock(input logic exp, input string tag);
    @(negedge clk);
    #1 chk(tag, {31'd0, locked}, {31'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #3 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk_lock(1'b1, "R1 locked after reset");
    bus_wr(8'h00, 32'hDEAD_BEEF, 1'b0, "R4 write dropped when locked");
    bus_wr(8'h64, 32'h1234_5678, 1'b0, "R4 second address dropped");
  endtask

  task automatic t_unlock_fwd();
    bus_wr(A_K0, V_K0, 1'b0, "R8 key0 write not forwarded");
    chk_lock(1'b1, "R6 only key0 correct");
    bus_wr(A_K1, V_K1, 1'b0, "R8 key1 write not forwarded");
    chk_lock(1'b0, "R2 unlocked after key0 then key1");
    bus_wr(8'h08, 32'h0000_0012, 1'b1, "R3 protected write passes");
    bus_wr(8'h98, 32'h0001_0000, 1'b1, "R3 high address passes");
    bus_wr(A_K1, V_K1, 1'b0, "R8 key rewrite while unlocked");
    chk_lock(1'b0, "R2 stays unlocked on key rewrite");
  endtask

  task automatic t_relock_zero();
    bus_wr(A_K0, 32'h0, 1'b0, "R8 zero key write");
    chk_lock(1'b1, "R5 zero to key0 relocks");
    bus_wr(A_K1, 32'h0, 1'b0, "R8 zero key1 write");
    chk_lock(1'b1, "R5 locked after both zero");
    bus_wr(8'h14, 32'h0000_0099, 1'b0, "R4 dropped after relock");
  endtask

  task automatic t_unlock_rev();
    bus_wr(A_K1, V_K1, 1'b0, "R8 key1 first");
    chk_lock(1'b1, "R6 only key1 correct");
    bus_wr(A_K0, V_K0, 1'b0, "R8 key0 second");
    chk_lock(1'b0, "R2 unlocked after key1 then key0");
  endtask

  task automatic t_near_miss();
    bus_wr(A_K0, V_K0 ^ 32'h0000_0001, 1'b0, "R8 near miss key0");
    chk_lock(1'b1, "R5 one bit off key0 relocks");
    bus_wr(8'h20, 32'h5, 1'b0, "R4 dropped after near miss");
    bus_wr(A_K0, V_K0, 1'b0, "R8 key0 restored");
    chk_lock(1'b0, "R2 unlocked after restoring key0");
    bus_wr(A_K1, V_K1 ^ 32'h8000_0000, 1'b0, "R8 near miss key1");
    chk_lock(1'b1, "R5 top bit off key1 relocks");
    bus_wr(A_K0, V_K1, 1'b0, "R8 swapped key");
    chk_lock(1'b1, "R6 key1 value in key0 slot");
  endtask

  task automatic t_idle_and_read();
    bus_wr(A_K0, V_K0, 1'b0, "R8 key0");
    bus_wr(A_K1, V_K1, 1'b0, "R8 key1");
    chk_lock(1'b0, "R2 unlocked before idle test");
    @(negedge clk);
    addr = A_K0; wdata = 32'h0; rd_en = 1'b1;
    #1 chk("R7 read while unlocked", {31'd0, reg_re}, 32'd1);
    @(posedge clk);
    #1 chk("R9 no strobe keeps unlocked", {31'd0, locked}, 32'd0);
    rd_en = 1'b0;
    #1 chk("R7 read low", {31'd0, reg_re}, 32'd0);
    bus_wr(A_K1, 32'hFFFF_FFFF, 1'b0, "R8 junk key1");
    chk_lock(1'b1, "R5 junk key1 relocks");
    @(negedge clk);
    addr = A_K1; wdata = V_K1; rd_en = 1'b1;
    #1 chk("R7 read while locked", {31'd0, reg_re}, 32'd1);
    @(posedge clk);
    #1 chk("R9 no strobe keeps locked", {31'd0, locked}, 32'd1);
    rd_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic t_reset_mid();
    bus_wr(A_K1, V_K1, 1'b0, "R8 key1 before reset");
    chk_lock(1'b0, "R2 unlocked before reset");
    do_reset();
    chk_lock(1'b1, "R1 locked after mid-run reset");
    bus_wr(8'h40, 32'h8, 1'b0, "R4 dropped after reset");
  endtask

  initial begin
    #12 rst_n = 1'b1;
    t_reset();
    t_unlock_fwd();
    t_relock_zero();
    t_unlock_rev();
    t_near_miss();
    t_idle_and_read();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule